// File: doc/BRIEF.md
# Adaptive Instruction Fetch Width Selector

This block sits ahead of the bus sequencer and decides how wide each instruction fetch request should be. Every fetch goes out either as an aligned 32-bit long word or as an aligned 16-bit word. The choice follows the port width that the slave acknowledged on the most recent completed instruction fetch. A 32-bit acknowledge keeps fetches at long-word width. A byte-wide or word-wide acknowledge drops the next fetch to word width. The outcome does not depend on the width with which that previous fetch was issued.

The sequencer reports each finished access with a completion pulse, a tag that says whether the access was an instruction fetch, and a termination code. Data accesses never change the prediction, and neither does a bus-error termination. A single register holds the prediction. The outgoing address is the incoming fetch address with its low bits cleared to match the chosen width.

Top module: `fetch_width_sel`

## Requirements
- R1: After synchronous reset, req_long_o is 1, so the first fetch request is long-word.
- R2: A completion with done_instr_i=1 and done_term_i=2'b10 (32-bit port acknowledge) sets req_long_o to 1 from the following cycle.
- R3: A completion with done_instr_i=1 and done_term_i=2'b00 (8-bit port) or 2'b01 (16-bit port) sets req_long_o to 0 from the following cycle.
- R4: R2 and R3 apply whatever the width of the request that completed, including a long-word request that ends on a narrow port and a word request that ends on a 32-bit port.
- R5: A completion with done_instr_i=0 (data access) leaves req_long_o unchanged, whatever its termination code.
- R6: An instruction completion with done_term_i=2'b11 (bus error) leaves req_long_o unchanged.
- R7: When req_long_o is 1, req_addr_o equals fetch_addr_i with bits [1:0] cleared.
- R8: When req_long_o is 0, req_addr_o equals fetch_addr_i with bit 0 cleared and bit 1 passed through.
- R9: In a cycle with done_i=0, req_long_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_addr_i | input | ADDR_W | Next instruction fetch address, byte granular |
| done_i | input | 1 | Pulses for one cycle when a bus access completes |
| done_instr_i | input | 1 | 1 when the completing access was an instruction fetch |
| done_term_i | input | 2 | Termination code: 00 byte port, 01 word port, 10 long port, 11 bus error |
| req_long_o | output | 1 | 1 asks for a long-word fetch, 0 for a word fetch |
| req_addr_o | output | ADDR_W | Fetch address aligned to the chosen width |

## Verification
The assertions assume that done_term_i and done_instr_i have meaning only in cycles where done_i is high. They also assume that a completion lasts exactly one cycle, so every completion cycle counts as a separate termination. The stimulus drives arbitrary values on the tag and code lines while done_i is low, which shows that those values are ignored. It also delivers completions back to back, so each one is a single-cycle event with no gap between them. Address and termination values are random, and the stream includes long runs of data completions and bus errors placed between instruction completions.

// File: rtl/fetch_width_pkg.sv
package fetch_width_pkg;

    typedef enum logic [1:0] {
        TERM_BYTE = 2'b00,
        TERM_WORD = 2'b01,
        TERM_LONG = 2'b10,
        TERM_BERR = 2'b11
    } term_e;

    typedef enum logic {
        FW_WORD = 1'b0,
        FW_LONG = 1'b1
    } fsize_e;

    typedef struct packed {
        logic  valid;
        logic  instr;
        term_e term;
    } compl_t;

    localparam fsize_e RESET_SIZE = FW_LONG;

    function automatic logic is_narrow(term_e t);
        return (t == TERM_BYTE) || (t == TERM_WORD);
    endfunction

    function automatic int unsigned low_zero_bits(fsize_e s);
        return (s == FW_LONG) ? 2 : 1;
    endfunction

endpackage

// File: rtl/fetch_size_pred.sv
module fetch_size_pred
    import fetch_width_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  compl_t cmpl,
    output fsize_e size_q
);
    logic   instr_evt;
    fsize_e size_d;

    assign instr_evt = cmpl.valid && cmpl.instr && (cmpl.term != TERM_BERR);

    always_comb begin
        size_d = size_q;
        if (instr_evt) begin
            if (is_narrow(cmpl.term)) size_d = FW_WORD;
            else                      size_d = FW_LONG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) size_q <= RESET_SIZE;
        else     size_q <= size_d;
    end

    AST_RESET_LONG: assert property (@(posedge clk) rst |=> size_q == FW_LONG); // R1
    AST_LONG_ACK: assert property (@(posedge clk) disable iff (rst)
        (cmpl.valid && cmpl.instr && cmpl.term == TERM_LONG) |=> size_q == FW_LONG); // R2
    AST_NARROW_ACK: assert property (@(posedge clk) disable iff (rst)
        (cmpl.valid && cmpl.instr && (cmpl.term == TERM_BYTE || cmpl.term == TERM_WORD))
        |=> size_q == FW_WORD); // R3
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmpl.valid && !cmpl.instr) |=> $stable(size_q)); // R5
    AST_BERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmpl.valid && cmpl.instr && cmpl.term == TERM_BERR) |=> $stable(size_q)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cmpl.valid |=> $stable(size_q)); // R9

endmodule

// File: rtl/fetch_addr_align.sv
module fetch_addr_align
    import fetch_width_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  fsize_e            size_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int MAX_LOW = 2;

    logic [MAX_LOW-1:0] low_keep;

    generate
        for (genvar b = 0; b < MAX_LOW; b++) begin : g_low
            always_comb low_keep[b] = (b >= low_zero_bits(size_i)) ? addr_i[b] : 1'b0;
        end
    endgenerate

    assign addr_o = {addr_i[ADDR_W-1:MAX_LOW], low_keep};

    always_comb begin
        AST_LONG_ALIGN: assert (size_i != FW_LONG || (addr_o[1:0] == 2'b00
            && addr_o[ADDR_W-1:2] == addr_i[ADDR_W-1:2])); // R7
        AST_WORD_ALIGN: assert (size_i != FW_WORD || (addr_o[0] == 1'b0
            && addr_o[ADDR_W-1:1] == addr_i[ADDR_W-1:1])); // R8
    end

endmodule

// File: rtl/fetch_width_sel.sv
module fetch_width_sel
    import fetch_width_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              done_i,
    input  logic              done_instr_i,
    input  logic [1:0]        done_term_i,
    output logic              req_long_o,
    output logic [ADDR_W-1:0] req_addr_o
);
    compl_t cmpl;
    fsize_e size_q;

    always_comb begin
        cmpl.valid = done_i;
        cmpl.instr = done_instr_i;
        cmpl.term  = term_e'(done_term_i);
    end

    fetch_size_pred u_pred (
        .clk    (clk),
        .rst    (rst),
        .cmpl   (cmpl),
        .size_q (size_q)
    );

    fetch_addr_align #(.ADDR_W(ADDR_W)) u_align (
        .addr_i (fetch_addr_i),
        .size_i (size_q),
        .addr_o (req_addr_o)
    );

    assign req_long_o = (size_q == FW_LONG);

endmodule

// File: tb/fetch_width_sel_test.sv
module fetch_width_sel_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] fetch_addr_i = '0;
    logic          done_i = 1'b0;
    logic          done_instr_i = 1'b0;
    logic [1:0]    done_term_i = 2'b00;
    logic          req_long_o;
    logic [AW-1:0] req_addr_o;

    int errors = 0;
    int checks = 0;
    int exp_long = 1;
    bit finished = 0;

    always #4 clk = ~clk;

    fetch_width_sel #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .fetch_addr_i(fetch_addr_i), .done_i(done_i),
        .done_instr_i(done_instr_i), .done_term_i(done_term_i),
        .req_long_o(req_long_o), .req_addr_o(req_addr_o)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] aligned(input logic [AW-1:0] a, input int lng);
        return lng != 0 ? {a[AW-1:2], 2'b00} : {a[AW-1:1], 1'b0};
    endfunction

    // one cycle: drive at negedge, clock edge, compare with the reference at the next negedge
    task automatic step(input logic [AW-1:0] a, input logic d, input logic ins, input logic [1:0] t);
        string tag;
        int prev;
        fetch_addr_i = a; done_i = d; done_instr_i = ins; done_term_i = t;
        prev = exp_long;
        @(negedge clk);
        if (!d)            tag = "R9";
        else if (!ins)     tag = "R5";
        else if (t == 2'b11) tag = "R6";
        else begin
            exp_long = (t == 2'b10) ? 1 : 0;
            if ((t == 2'b10) != (prev != 0)) tag = "R4";
            else tag = (t == 2'b10) ? "R2" : "R3";
        end
        chk(tag, {31'd0, req_long_o}, AW'(exp_long));
        chk(exp_long != 0 ? "R7" : "R8", req_addr_o, aligned(a, exp_long));
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1", {31'd0, req_long_o}, 32'd1);
        exp_long = 1;
        step(32'h1000_0007, 1'b0, 1'b1, 2'b01);  // R9 idle with junk on tag/code
        step(32'h1000_0003, 1'b1, 1'b1, 2'b10);  // R2 long stays long
        step(32'h1000_0006, 1'b1, 1'b0, 2'b00);  // R5 data byte ack
        step(32'h1000_0005, 1'b1, 1'b1, 2'b00);  // R4 long issued, byte port -> word
        step(32'h1000_0003, 1'b1, 1'b0, 2'b10);  // R5 data long ack while word
        step(32'h1000_0002, 1'b1, 1'b1, 2'b01);  // R3 word port keeps word
        step(32'h1000_0001, 1'b1, 1'b1, 2'b11);  // R6 bus error holds
        step(32'h1000_000b, 1'b1, 1'b1, 2'b10);  // R4 word issued, long port -> long
        step(32'h1000_000e, 1'b1, 1'b1, 2'b11);  // R6 bus error holds long
        step(32'h1000_000f, 1'b1, 1'b1, 2'b01);  // R3 word port -> word
        step(32'hffff_ffff, 1'b0, 1'b0, 2'b10);  // R9 / R8
        for (int i = 0; i < 2000; i++)
            step($urandom, 1'($urandom), 1'($urandom), 2'($urandom));
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_long = 1;
        chk("R1", {31'd0, req_long_o}, 32'd1);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule